// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip's boundary-scan logic. It runs the sixteen-state controller clocked by the test clock, holds a 4-bit instruction register, and decodes the current instruction into a choice of data path between the serial input and the serial output. There are three paths: a 1-bit bypass stage, a 32-bit identification register, and a boundary chain that lives outside the block.

The boundary chain connects through a serial output and a serial return. The block drives the chain's capture, shift and update strobes only while that chain is the selected path. It also raises three level outputs that the pad ring uses: one makes the pins drive from the chain, one holds them at the chain's values, and one floats them.

The serial output changes on the falling edge of the test clock. It is enabled only while the controller shifts the instruction or data path. An active-low asynchronous reset returns the controller to its reset state.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While trst_n is low the controller sits in Test-Logic-Reset at once, without a clock edge: tdo_en and tdo are 0, every mode output is 0, and the active instruction is IDCODE (4'b0010).
- R2: Five consecutive rising tck edges with tms high bring the controller to Test-Logic-Reset from any state, and reaching that state makes IDCODE (4'b0010) the active instruction.
- R3: In Capture-IR the instruction shift stage loads 4'b0001. It shifts out least significant bit first, with tdi entering at the most significant bit.
- R4: When IDCODE (4'b0010) is active, Capture-DR loads 32'h01F2701D, which is then shifted out least significant bit first.
- R5: The 1-bit bypass stage loads 0 in Capture-DR and delays tdi by one shift. It is the selected path for 4'b1111, HIGHZ 4'b0100, CLAMP 4'b0101, the two debug codes 4'b0110 and 4'b0111, and every code from 4'b1000 to 4'b1110.
- R6: EXTEST 4'b0000, SAMPLE 4'b0001 and EXTEST with pull-ups 4'b0011 select the external chain. bsr_si follows tdi, and tdo carries bsr_so, so a 338-cell chain adds 338 shifts between tdi and tdo.
- R7: bsr_capture, bsr_shift and bsr_update are high in Capture-DR, Shift-DR and Update-DR, but only while the external chain is selected. At most one of them is high at a time.
- R8: mode_extest is high for 4'b0000, 4'b0011 and 4'b0101. mode_clamp is high only for 4'b0101, and mode_highz only for 4'b0100. A new instruction takes effect only on Update-IR; shifting the instruction stage leaves the modes unchanged.
- R9: tdo and tdo_en change on the falling tck edge. tdo_en is 1 only while the controller is in Shift-IR or Shift-DR; otherwise both tdo_en and tdo are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for tdo |
| bsr_si | output | 1 | Serial data to the external boundary chain |
| bsr_so | input | 1 | Serial return from the external boundary chain |
| bsr_capture | output | 1 | Chain capture strobe |
| bsr_shift | output | 1 | Chain shift strobe |
| bsr_update | output | 1 | Chain update strobe |
| mode_extest | output | 1 | Pins driven from the chain |
| mode_clamp | output | 1 | Pins held at the chain while bypass is selected |
| mode_highz | output | 1 | All pins floated |

## Verification
The hardest case to reach is the full pass through the external chain. The bench must load EXTEST, capture a known pattern into a 338-cell chain model of its own, and then shift 342 bits in one Shift-DR visit. The first 338 bits out must match the captured pattern. The last four must echo the first four bits sent, which shows that the chain really sits in the path. A second hard case is an asynchronous reset pulse in the middle of a shift. The bench drops trst_n between clock edges while CLAMP is active, and checks that tdo_en and the modes clear at once.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR     = 4'hA,
    ST_IDLE    = 4'h3,
    ST_SEL_DR  = 4'h0,
    ST_CAP_DR  = 4'h1,
    ST_SH_DR   = 4'h2,
    ST_EX1_DR  = 4'h4,
    ST_PAU_DR  = 4'h5,
    ST_EX2_DR  = 4'h6,
    ST_UP_DR   = 4'h7,
    ST_SEL_IR  = 4'h8,
    ST_CAP_IR  = 4'h9,
    ST_SH_IR   = 4'hB,
    ST_EX1_IR  = 4'hC,
    ST_PAU_IR  = 4'hD,
    ST_EX2_IR  = 4'hE,
    ST_UP_IR   = 4'hF
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_EXT_PU  = 4'b0011;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0100;
  localparam logic [IR_W-1:0] OP_CLAMP   = 4'b0101;
  localparam logic [IR_W-1:0] OP_DBG_EN  = 4'b0110;
  localparam logic [IR_W-1:0] OP_DBG_REQ = 4'b0111;

  typedef enum logic [1:0] {
    PATH_BYPASS = 2'd0,
    PATH_ID     = 2'd1,
    PATH_BOUND  = 2'd2
  } dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     extest;
    logic     clamp;
    logic     highz;
  } op_decode_t;

  function automatic op_decode_t decode_op(input logic [IR_W-1:0] op);
    op_decode_t d;
    d = '{path: PATH_BYPASS, extest: 1'b0, clamp: 1'b0, highz: 1'b0};
    case (op)
      OP_EXTEST: begin d.path = PATH_BOUND; d.extest = 1'b1; end
      OP_SAMPLE: d.path = PATH_BOUND;
      OP_IDCODE: d.path = PATH_ID;
      OP_EXT_PU: begin d.path = PATH_BOUND; d.extest = 1'b1; end
      OP_HIGHZ:  d.highz = 1'b1;
      OP_CLAMP:  begin d.clamp = 1'b1; d.extest = 1'b1; end
      default:   d.path = PATH_BYPASS;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e st
);

  function automatic tap_state_e next_state(input tap_state_e s, input logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_IDLE;
      ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UP_DR  : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UP_IR  : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UP_IR  : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_IDLE;
    endcase
  endfunction

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= ST_TLR;
    else         st <= next_state(st, tms);
  end

  // Checker: run length of tms-high edges, saturating at five.
  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             tms_run <= 3'd0;
    else if (!tms)           tms_run <= 3'd0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  a_r2_tms_five: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run == 3'd5) |-> (st == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter logic [IR_W-1:0] CAPTURE_VAL = 4'b0001,
  parameter logic [IR_W-1:0] RESET_OP    = OP_IDCODE
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      st,
  input  logic            tdi,
  output logic            ir_so,
  output logic [IR_W-1:0] ir
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) ir_sr <= CAPTURE_VAL;
    else if (st == ST_CAP_IR) ir_sr <= CAPTURE_VAL;
    else if (st == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              ir <= RESET_OP;
    else if (st == ST_TLR)    ir <= RESET_OP;
    else if (st == ST_UP_IR)  ir <= ir_sr;
  end

  assign ir_so = ir_sr[0];

  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_CAP_IR) |=> (ir_sr == CAPTURE_VAL));
  a_r8_update_loads: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_UP_IR) |=> (ir == $past(ir_sr)));
  a_r8_hold_otherwise: assert property (@(posedge tck) disable iff (!trst_n)
    (st != ST_UP_IR && st != ST_TLR) |=> $stable(ir));
  a_r2_reset_state_op: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_TLR) |=> (ir == RESET_OP));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h01F2701D
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e st,
  input  dr_path_e   path,
  input  logic       tdi,
  input  logic       bsr_so,
  output logic       dr_so
);

  logic [ID_W-1:0] id_sr;
  logic            byp;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= ID_VAL;
    end else if (path == PATH_ID) begin
      if (st == ST_CAP_DR)     id_sr <= ID_VAL;
      else if (st == ST_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp <= 1'b0;
    end else if (path == PATH_BYPASS) begin
      if (st == ST_CAP_DR)     byp <= 1'b0;
      else if (st == ST_SH_DR) byp <= tdi;
    end
  end

  always_comb begin
    case (path)
      PATH_ID:    dr_so = id_sr[0];
      PATH_BOUND: dr_so = bsr_so;
      default:    dr_so = byp;
    endcase
  end

  a_r5_bypass_zero: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_CAP_DR && path == PATH_BYPASS) |=> (byp == 1'b0));
  a_r4_id_lsb_set: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_CAP_DR && path == PATH_ID) |=> (id_sr[0] == 1'b1));

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import tap_pkg::*;
#(
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h01F2701D
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  output logic bsr_si,
  input  logic bsr_so,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic mode_extest,
  output logic mode_clamp,
  output logic mode_highz
);

  tap_state_e      st;
  logic [IR_W-1:0] ir;
  logic            ir_so;
  logic            dr_so;
  op_decode_t      dec;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .st(st));

  tap_ir #(.CAPTURE_VAL(4'b0001), .RESET_OP(OP_IDCODE)) u_ir (
    .tck(tck), .trst_n(trst_n), .st(st), .tdi(tdi), .ir_so(ir_so), .ir(ir));

  assign dec = decode_op(ir);

  tap_dr #(.ID_W(ID_W), .ID_VAL(ID_VAL)) u_dr (
    .tck(tck), .trst_n(trst_n), .st(st), .path(dec.path), .tdi(tdi),
    .bsr_so(bsr_so), .dr_so(dr_so));

  logic bound_sel;
  assign bound_sel   = (dec.path == PATH_BOUND);
  assign bsr_si      = tdi;
  assign bsr_capture = bound_sel && (st == ST_CAP_DR);
  assign bsr_shift   = bound_sel && (st == ST_SH_DR);
  assign bsr_update  = bound_sel && (st == ST_UP_DR);
  assign mode_extest = dec.extest;
  assign mode_clamp  = dec.clamp;
  assign mode_highz  = dec.highz;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (st == ST_SH_IR) || (st == ST_SH_DR);
      tdo    <= (st == ST_SH_IR) ? ir_so : ((st == ST_SH_DR) ? dr_so : 1'b0);
    end
  end

  a_r7_strobes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));
  a_r7_strobe_needs_chain: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_shift || bsr_capture) |-> (!mode_highz && !mode_clamp));
  a_r8_modes_disjoint: assert property (@(posedge tck) disable iff (!trst_n)
    !(mode_highz && mode_extest));
  a_r9_quiet_in_idle: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_IDLE && $past(st) == ST_IDLE) |-> (!tdo_en && !tdo));

endmodule

// File: tb/jtag_tap_ctrl_test.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_test;

  localparam int CHAIN = 338;
  localparam logic [31:0] IDV = 32'h01F2701D;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_so;
  logic tdo, tdo_en, bsr_si, bsr_capture, bsr_shift, bsr_update;
  logic mode_extest, mode_clamp, mode_highz;

  always #2 tck = ~tck;

  jtag_tap_ctrl uut (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .tdo_en(tdo_en), .bsr_si(bsr_si), .bsr_so(bsr_so), .bsr_capture(bsr_capture),
    .bsr_shift(bsr_shift), .bsr_update(bsr_update), .mode_extest(mode_extest),
    .mode_clamp(mode_clamp), .mode_highz(mode_highz));

  // External boundary chain model
  function automatic logic pat(input int i);
    return ((i * 7) % 5) < 2;
  endfunction
  logic [CHAIN-1:0] chain;
  int n_cap = 0, n_sh = 0, n_up = 0;
  always @(posedge tck) begin
    if (bsr_capture) begin
      for (int i = 0; i < CHAIN; i++) chain[i] <= pat(i);
      n_cap <= n_cap + 1;
    end else if (bsr_shift) begin
      chain <= {bsr_si, chain[CHAIN-1:1]};
      n_sh <= n_sh + 1;
    end
    if (bsr_update) n_up <= n_up + 1;
  end
  assign bsr_so = chain[0];

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { string tag; int len; logic [63:0] val; } item_t;
  item_t exp_q[$];
  item_t obs_q[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops observed and expected items and compares them
  initial begin
    forever begin
      item_t o, e;
      wait (obs_q.size() > 0);
      o = obs_q.pop_front();
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL %s actual=%h expected=<none>", o.tag, o.val);
      end else begin
        e = exp_q.pop_front();
        check(e.tag, o.val, e.val);
      end
    end
  end

  task automatic push_chunks(input string tag, input logic [399:0] v, input int n, input bit is_exp);
    for (int b = 0; b < n; b += 64) begin
      item_t it;
      it.tag = tag;
      it.len = (n - b > 64) ? 64 : n - b;
      it.val = '0;
      for (int k = 0; k < it.len; k++) it.val[k] = v[b + k];
      if (is_exp) exp_q.push_back(it); else obs_q.push_back(it);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo; tms = m; tdi = d;
    @(posedge tck);
  endtask

  logic en_seen;
  logic mid_clamp;

  // From Run-Test/Idle; returns to Run-Test/Idle
  task automatic shift_ir(input logic [3:0] op, output logic [3:0] got);
    logic x;
    step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], got[i]);
      if (i == 0) en_seen = tdo_en;
      if (i == 3) mid_clamp = mode_clamp;
    end
    step(1, 0, x); step(0, 0, x);
  endtask

  task automatic shift_dr(input string tag, input int n, input logic [399:0] din);
    logic x;
    logic [399:0] got;
    got = '0;
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], got[i]);
      if (i == 0) en_seen = tdo_en;
    end
    step(1, 0, x); step(0, 0, x);
    push_chunks(tag, got, n, 0);
  endtask

  task automatic load_op(input logic [3:0] op);
    logic [3:0] g;
    shift_ir(op, g);
  endtask

  task automatic settle;
    logic x;
    step(0, 0, x);
    @(negedge tck); #1;
  endtask

  task automatic bypass_test(input string tag, input logic [3:0] op);
    logic [399:0] d, e;
    load_op(op);
    d = '0; e = '0;
    for (int i = 0; i < 12; i++) d[i] = pat(i + op);
    for (int i = 1; i < 12; i++) e[i] = d[i-1];
    push_chunks(tag, e, 12, 1);
    shift_dr(tag, 12, d);
  endtask

  initial begin
    logic [3:0] g;
    logic [399:0] d, e;
    logic x;
    int c0, s0, u0;
    // R1: reset state, asynchronous
    #5;
    check("R1 tdo_en in reset", tdo_en, 0);
    check("R1 modes in reset", {mode_extest, mode_clamp, mode_highz}, 3'b000);
    @(negedge tck); #1; trst_n = 1'b1;
    step(0, 0, x);
    settle();
    check("R9 tdo_en idle", {tdo_en, tdo}, 2'b00);

    // R1/R4: default instruction is IDCODE
    push_chunks("R4 idcode after reset", {368'b0, IDV}, 32, 1);
    shift_dr("R4 idcode after reset", 32, '0);
    check("R9 tdo_en in Shift-DR", en_seen, 1);
    settle();
    check("R9 tdo_en back in idle", tdo_en, 0);

    // R3: IR capture value
    shift_ir(4'b1111, g);
    check("R3 captured ir bits", g, 4'b0001);
    check("R9 tdo_en in Shift-IR", en_seen, 1);

    // R5: bypass variants
    bypass_test("R5 bypass 1111", 4'b1111);
    bypass_test("R5 unlisted 1000", 4'b1000);
    bypass_test("R5 unlisted 1110", 4'b1110);
    bypass_test("R5 debug 0110", 4'b0110);
    bypass_test("R5 debug 0111", 4'b0111);
    settle();
    check("R8 modes after debug op", {mode_extest, mode_clamp, mode_highz}, 3'b000);

    bypass_test("R5 highz path", 4'b0100);
    settle();
    check("R8 highz modes", {mode_extest, mode_clamp, mode_highz}, 3'b001);
    bypass_test("R5 clamp path", 4'b0101);
    settle();
    check("R8 clamp modes", {mode_extest, mode_clamp, mode_highz}, 3'b110);

    // R8: modes unchanged while shifting IR
    shift_ir(4'b0100, g);
    check("R8 clamp held during IR shift", mid_clamp, 1);
    settle();
    check("R8 highz after update", {mode_extest, mode_clamp, mode_highz}, 3'b001);

    // R7: no chain strobes with IDCODE
    load_op(4'b0010);
    c0 = n_cap; s0 = n_sh; u0 = n_up;
    push_chunks("R4 idcode op", {368'b0, IDV}, 32, 1);
    shift_dr("R4 idcode op", 32, '0);
    settle();
    check("R7 no strobes for idcode", {n_cap - c0, n_sh - s0, n_up - u0}, 96'd0);

    // R6/R7: EXTEST full chain pass
    load_op(4'b0000);
    settle();
    check("R8 extest modes", {mode_extest, mode_clamp, mode_highz}, 3'b100);
    c0 = n_cap; s0 = n_sh; u0 = n_up;
    d = '0; e = '0;
    for (int i = 0; i < 4; i++) d[i] = ~pat(i);
    for (int i = 0; i < CHAIN; i++) e[i] = pat(i);
    for (int i = 0; i < 4; i++) e[CHAIN + i] = d[i];
    push_chunks("R6 extest chain", e, CHAIN + 4, 1);
    shift_dr("R6 extest chain", CHAIN + 4, d);
    settle();
    check("R7 capture count", n_cap - c0, 1);
    check("R7 shift count", n_sh - s0, CHAIN + 4);
    check("R7 update count", n_up - u0, 1);

    // R6: SAMPLE and pull-up EXTEST also use chain
    load_op(4'b0001);
    settle();
    check("R8 sample modes", {mode_extest, mode_clamp, mode_highz}, 3'b000);
    d = '0; e = '0;
    for (int i = 0; i < 8; i++) e[i] = pat(i);
    push_chunks("R6 sample chain", e, 8, 1);
    shift_dr("R6 sample chain", 8, d);
    load_op(4'b0011);
    settle();
    check("R8 pullup extest modes", {mode_extest, mode_clamp, mode_highz}, 3'b100);
    c0 = n_sh;
    push_chunks("R6 pullup chain", e, 8, 1);
    shift_dr("R6 pullup chain", 8, d);
    settle();
    check("R6 pullup shifts chain", n_sh - c0, 8);

    // R2: five tms-high edges reset to IDCODE
    load_op(4'b1111);
    for (int i = 0; i < 5; i++) step(1, 0, x);
    step(0, 0, x);
    push_chunks("R2 tms reset idcode", {368'b0, IDV}, 32, 1);
    shift_dr("R2 tms reset idcode", 32, '0);

    // R1: async reset mid-shift with clamp active
    load_op(4'b0101);
    step(1, 0, x); step(0, 0, x); step(0, 0, x); step(0, 1, x);
    @(negedge tck); #1.5;
    trst_n = 1'b0;
    #0.2;
    check("R1 async reset tdo_en", tdo_en, 0);
    check("R1 async reset modes", {mode_extest, mode_clamp, mode_highz}, 3'b000);
    tms = 1'b0;
    @(negedge tck); #1; trst_n = 1'b1;
    step(0, 0, x);
    push_chunks("R1 idcode after trst", {368'b0, IDV}, 32, 1);
    shift_dr("R1 idcode after trst", 32, '0);

    #20;
    wait (obs_q.size() == 0);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule